// File: doc/BRIEF.md
# Approximate Full-Adder Ripple Adder

This block adds two unsigned operands and a carry-in through a chain of one-bit cells. The lowest cells are approximate full adders. They trade a few wrong truth-table entries for a smaller, faster cell. The remaining cells are exact full adders.

The number of approximate positions is a parameter. A static 2-bit mode input chooses one of four approximate cell variants, and every approximate position uses the same variant. The carry always ripples from one cell to the next, whichever variant is active. The block is purely combinational. It suits error-tolerant datapaths such as pixel or transform arithmetic, where small errors in the low-order bits are acceptable.

Each approximate variant builds its outputs from cheap stand-ins. One stand-in is the inverted carry used as the sum. Another is operand A used as the carry. In the requirements below, a cell input combination is written as the 3-bit value {a, b, c}, where a and b are the operand bits and c is the carry entering that cell.

Top module: `approx_ripple_adder`

## Requirements
- R1: Bit positions at or above APPROX_BITS use exact full-adder cells. With APPROX_BITS = 0, {cout_o, sum_o} equals a_i + b_i + cin_i for every input.
- R2: mode_i selects the variant used by every approximate position: 2'b00 selects variant A, 2'b01 variant B, 2'b10 variant C and 2'b11 variant D.
- R3: In variant A the carry is b & (a | c). This is exact except that input 101 gives 0. The sum is a | b when that carry is 0, and a & b & c when it is 1. The sum is therefore wrong only for inputs 001 and 101.
- R4: In variant B the carry is the exact majority for all eight inputs. The sum is the complement of that carry, so it is wrong only for inputs 000 and 111.
- R5: In variant C the carry is the variant A carry and the sum is its complement. This gives one carry error (101) and three sum errors (000, 101, 111).
- R6: In variant D the carry equals a, which is wrong for inputs 011 and 100. The sum uses the variant A rule with this carry, which is wrong for inputs 001, 011 and 100.
- R7: The carry into position 0 is cin_i. The carry out of each position is the carry into the next position, and cout_o is the carry out of the top position.
- R8: The outputs depend only on the present inputs: no clock, no reset and no stored state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| cin_i | input | 1 | Carry into bit 0 |
| mode_i | input | 2 | Approximate cell variant select (static) |
| sum_o | output | WIDTH | Sum bits |
| cout_o | output | 1 | Carry out of the top bit |

## Verification
The bound checker evaluates every position whenever the inputs change. It checks the internal carry chain against cin_i and cout_o. It checks that each exact position satisfies a full-adder relation with its neighbouring carries. For each approximate position it checks the properties of the active variant: sum equals the inverted carry in variants B and C, carry equals the majority in B, carry equals a in D, and in A a carry never appears without b.

The complete truth table of each variant needs the bench. It drives a single-bit instance through all 32 combinations of mode and cell input. Two further properties also come only from the bench's scenarios: the multi-bit results of a mixed-boundary adder against a ripple model built from those truth tables, and exactness when no position is approximate.

// File: rtl/approx_add_pkg.sv
package approx_add_pkg;
  typedef enum logic [1:0] {
    CELL_VAR_A = 2'b00,
    CELL_VAR_B = 2'b01,
    CELL_VAR_C = 2'b10,
    CELL_VAR_D = 2'b11
  } cell_mode_e;
endpackage

// File: rtl/fa_exact.sv
module fa_exact (
  input  logic x_i,
  input  logic y_i,
  input  logic c_i,
  output logic s_o,
  output logic c_o
);
  always_comb begin
    s_o = x_i ^ y_i ^ c_i;
    c_o = (x_i & y_i) | (x_i & c_i) | (y_i & c_i);
  end
endmodule

// File: rtl/fa_approx.sv
module fa_approx
  import approx_add_pkg::*;
(
  input  logic       x_i,
  input  logic       y_i,
  input  logic       c_i,
  input  logic [1:0] mode_i,
  output logic       s_o,
  output logic       c_o
);
  logic carry_trim;   // majority with the x&c term dropped
  logic carry_full;   // true majority
  logic all_ones;
  logic any_op;
  cell_mode_e mode;

  always_comb begin
    mode       = cell_mode_e'(mode_i);
    carry_trim = y_i & (x_i | c_i);
    carry_full = (x_i & y_i) | (x_i & c_i) | (y_i & c_i);
    all_ones   = x_i & y_i & c_i;
    any_op     = x_i | y_i;
    unique case (mode)
      CELL_VAR_A: begin
        c_o = carry_trim;
        s_o = carry_trim ? all_ones : any_op;
      end
      CELL_VAR_B: begin
        c_o = carry_full;
        s_o = ~carry_full;
      end
      CELL_VAR_C: begin
        c_o = carry_trim;
        s_o = ~carry_trim;
      end
      default: begin
        c_o = x_i;
        s_o = x_i ? all_ones : any_op;
      end
    endcase
  end
endmodule

// File: rtl/approx_ripple_adder.sv
module approx_ripple_adder #(
  parameter int WIDTH       = 8,
  parameter int APPROX_BITS = 4
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  input  logic [1:0]       mode_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o
);
  localparam int NUM_APPROX = (APPROX_BITS > WIDTH) ? WIDTH :
                              (APPROX_BITS < 0) ? 0 : APPROX_BITS;

  logic [WIDTH:0] carry;

  assign carry[0] = cin_i;
  assign cout_o   = carry[WIDTH];

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    if (i < NUM_APPROX) begin : g_apx
      fa_approx u_cell (
        .x_i   (a_i[i]),
        .y_i   (b_i[i]),
        .c_i   (carry[i]),
        .mode_i(mode_i),
        .s_o   (sum_o[i]),
        .c_o   (carry[i+1])
      );
    end else begin : g_exa
      fa_exact u_cell (
        .x_i(a_i[i]),
        .y_i(b_i[i]),
        .c_i(carry[i]),
        .s_o(sum_o[i]),
        .c_o(carry[i+1])
      );
    end
  end
endmodule

// File: rtl/approx_ripple_adder_chk.sv
module approx_ripple_adder_chk
  import approx_add_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int APPROX_BITS = 4
) (
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic             cin_i,
  input logic [1:0]       mode_i,
  input logic [WIDTH-1:0] sum_o,
  input logic             cout_o,
  input logic [WIDTH:0]   carry
);
  localparam int NUM_APPROX = (APPROX_BITS > WIDTH) ? WIDTH :
                              (APPROX_BITS < 0) ? 0 : APPROX_BITS;

  logic known;
  always_comb known = !$isunknown({a_i, b_i, cin_i, mode_i});

  always_comb begin
    if (known) begin
      // R7
      chain_ends_chk: assert (carry[0] == cin_i && carry[WIDTH] == cout_o);
    end
  end

  for (genvar i = 0; i < WIDTH; i++) begin : g_chk
    if (i >= NUM_APPROX) begin : g_exa
      always_comb begin
        if (known) begin
          // R1
          exact_pos_chk: assert ({carry[i+1], sum_o[i]} ==
                                 2'(a_i[i]) + 2'(b_i[i]) + 2'(carry[i]));
        end
      end
    end else begin : g_apx
      always_comb begin
        if (known) begin
          if (mode_i == CELL_VAR_A) begin
            // R3
            var_a_carry_chk: assert (!carry[i+1] || b_i[i]);
          end
          if (mode_i == CELL_VAR_B) begin
            // R4
            var_b_sum_chk: assert (sum_o[i] == !carry[i+1]);
            // R4
            var_b_carry_chk: assert ({carry[i+1], 1'b0} <=
                                     2'(a_i[i]) + 2'(b_i[i]) + 2'(carry[i]) &&
                                     2'(a_i[i]) + 2'(b_i[i]) + 2'(carry[i]) <=
                                     {carry[i+1], 1'b1});
          end
          if (mode_i == CELL_VAR_C) begin
            // R5
            var_c_sum_chk: assert (sum_o[i] == !carry[i+1]);
          end
          if (mode_i == CELL_VAR_D) begin
            // R6
            var_d_carry_chk: assert (carry[i+1] == a_i[i]);
          end
        end
      end
    end
  end
endmodule

bind approx_ripple_adder approx_ripple_adder_chk #(
  .WIDTH      (WIDTH),
  .APPROX_BITS(APPROX_BITS)
) u_chk (
  .a_i   (a_i),
  .b_i   (b_i),
  .cin_i (cin_i),
  .mode_i(mode_i),
  .sum_o (sum_o),
  .cout_o(cout_o),
  .carry (carry)
);

// File: tb/tb_approx_ripple_adder.sv
module tb_approx_ripple_adder;
  localparam int W = 8;
  localparam int L = 4;

  logic clk = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  logic [W-1:0] a, b, sum, sum_x;
  logic         cin, cout, cout_x;
  logic [1:0]   mode;
  logic         s1, c1;

  approx_ripple_adder #(.WIDTH(W), .APPROX_BITS(L)) dut (
    .a_i(a), .b_i(b), .cin_i(cin), .mode_i(mode), .sum_o(sum), .cout_o(cout));
  approx_ripple_adder #(.WIDTH(W), .APPROX_BITS(0)) dut_exact (
    .a_i(a), .b_i(b), .cin_i(cin), .mode_i(mode), .sum_o(sum_x), .cout_o(cout_x));
  approx_ripple_adder #(.WIDTH(1), .APPROX_BITS(1)) dut_cell (
    .a_i(a[0]), .b_i(b[0]), .cin_i(cin), .mode_i(mode), .sum_o(s1), .cout_o(c1));

  // Truth tables from R3-R6, bit index = {a,b,c}
  function automatic logic [1:0] cell_ref(input logic [1:0] m, input logic [2:0] abc);
    logic [7:0] sm, cm;
    case (m)
      2'b00:   begin sm = 8'hB4; cm = 8'hC8; end
      2'b01:   begin sm = 8'h17; cm = 8'hE8; end
      2'b10:   begin sm = 8'h37; cm = 8'hC8; end
      default: begin sm = 8'h8C; cm = 8'hF0; end
    endcase
    return {cm[abc], sm[abc]};
  endfunction

  function automatic logic [W:0] add_ref(input logic [W-1:0] x, input logic [W-1:0] y,
                                         input logic ci, input logic [1:0] m);
    logic [W:0] r;
    logic       c;
    logic [1:0] cs;
    c = ci;
    r = '0;
    for (int i = 0; i < W; i++) begin
      if (i < L) cs = cell_ref(m, {x[i], y[i], c});
      else       cs = {2'(x[i]) + 2'(y[i]) + 2'(c)};
      r[i] = cs[0];
      c    = cs[1];
    end
    r[W] = c;
    return r;
  endfunction

  task automatic check(input string req, input logic [W:0] act, input logic [W:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h (a=%h b=%h cin=%b mode=%b)",
               req, act, exp, a, b, cin, mode);
    end
  endtask

  task automatic drive(input logic [W-1:0] x, input logic [W-1:0] y,
                       input logic ci, input logic [1:0] m);
    @(posedge clk);
    a = x; b = y; cin = ci; mode = m;
    @(negedge clk);
  endtask

  task automatic t_zero();
    for (int m = 0; m < 4; m++) begin
      drive('0, '0, 1'b0, 2'(m));
      // R8 outputs settle from inputs alone; R2 variant per mode
      check("R8", {cout, sum}, add_ref('0, '0, 1'b0, 2'(m)));
    end
  endtask

  task automatic t_cells();
    for (int m = 0; m < 4; m++) begin
      for (int v = 0; v < 8; v++) begin
        drive({{(W-1){1'b0}}, v[2]}, {{(W-1){1'b0}}, v[1]}, v[0], 2'(m));
        case (m)
          0: check("R3", {{(W-1){1'b0}}, c1, s1}, {{(W-1){1'b0}}, cell_ref(2'(m), 3'(v))});
          1: check("R4", {{(W-1){1'b0}}, c1, s1}, {{(W-1){1'b0}}, cell_ref(2'(m), 3'(v))});
          2: check("R5", {{(W-1){1'b0}}, c1, s1}, {{(W-1){1'b0}}, cell_ref(2'(m), 3'(v))});
          default: check("R6", {{(W-1){1'b0}}, c1, s1}, {{(W-1){1'b0}}, cell_ref(2'(m), 3'(v))});
        endcase
      end
    end
  endtask

  task automatic t_exact();
    for (int k = 0; k < 40; k++) begin
      drive(W'($urandom), W'($urandom), 1'($urandom), 2'($urandom));
      // R1 no approximate position means an exact sum in every mode
      check("R1", {cout_x, sum_x}, (W+1)'(a) + (W+1)'(b) + (W+1)'(cin));
    end
    drive('1, '1, 1'b1, 2'b11);
    check("R1", {cout_x, sum_x}, {1'b1, {W{1'b1}}});
  endtask

  task automatic t_mixed();
    for (int m = 0; m < 4; m++) begin
      for (int k = 0; k < 30; k++) begin
        drive(W'($urandom), W'($urandom), 1'($urandom), 2'(m));
        // R2 mode picks the variant; R1 upper bits exact
        check("R2", {cout, sum}, add_ref(a, b, cin, 2'(m)));
      end
    end
  endtask

  task automatic t_ripple();
    // R7 carry chain: a long propagate run across the boundary
    drive('1, '0, 1'b1, 2'b01);
    check("R7", {cout, sum}, add_ref('1, '0, 1'b1, 2'b01));
    check("R7", {cout, sum}, {1'b1, {W{1'b0}}});
    drive({W{1'b0}} | W'(8'h0F), W'(8'h01), 1'b0, 2'b01);
    check("R7", {cout, sum}, add_ref(a, b, 1'b0, 2'b01));
    drive(W'(8'hF0), W'(8'h10), 1'b0, 2'b00);
    check("R7", {cout, sum}, add_ref(a, b, 1'b0, 2'b00));
    // R6 variant D ignores cin for the carry into bit 1
    drive(W'(8'h0E), W'(8'h00), 1'b1, 2'b11);
    check("R6", {cout, sum}, add_ref(a, b, 1'b1, 2'b11));
  endtask

  initial begin
    a = '0; b = '0; cin = 1'b0; mode = 2'b00;
    t_zero();
    t_cells();
    t_exact();
    t_mixed();
    t_ripple();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule